// File: doc/BRIEF.md
# Interpacket Gap Bit-Resolution Meter

This block sits on the receive path of a 10 Gb/s link that uses 64b/66b line coding. It takes over after block alignment and descrambling. Each cycle it may accept one coded block, given as its 2-bit sync header and its 8-bit block-type byte. It decodes where each frame ends (a terminate block) and where the next one begins (a start block). From these points it measures how far apart the frames are, with single-bit precision rather than a coarse timestamp clock.

For every start block it emits one result on a valid/data interface, one cycle after the start block is accepted. The result holds three measurements and two flags:

- the gap as a count of idle character slots;
- the same gap in line bit times, with the 2-bit sync headers of crossed blocks included;
- the start-to-start delay in bit times;
- a flag saying whether the gap value is trustworthy;
- a flag saying whether the delay value is trustworthy.

Software can scale the bit counts by roughly 97 ps per bit to obtain time. The data bytes of a block do not affect any measurement, so only the header and type byte enter the block.

Top module: `ipg_bit_meter`

## Requirements
- R1: After reset `res_valid` is low, and it stays low until a start block is accepted.
- R2: The sync header selects the block class: 2'b10 is a control block and 2'b01 is a data block. The type byte selects the control meaning:
  - 8'h1E is an all-idle block.
  - 8'h78 is a start in lane 0.
  - 8'h33 is a start in lane 4.
  - 8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1 and 8'hFF are a terminate in lanes 0 to 7 respectively.
- R3: Every accepted start block produces exactly one `res_valid` pulse, one cycle later. No other block produces a pulse.
- R4: `res_gap_idles` equals the number of character slots strictly after the terminate lane and before the start lane. Each block holds 8 slots.
- R5: `res_gap_bits` equals the line bit distance from the first slot after the terminate to the start slot. A block spans 66 bits, slot k of a block begins at bit 2+8k, and each slot is 8 bits.
- R6: `res_ipd_bits` equals the line bit distance between the previous start slot and this start slot.
- R7: A block whose sync header is 2'b00 or 2'b11 discards the gap in progress. The next result then has `res_gap_ok`=0 with both gap fields 0. The delay measurement keeps counting across such a block.
- R8: A data block, or a control block with an unlisted type byte, discards the gap in progress in the same way as R7.
- R9: A start that has no preceding terminate since the last start gives `res_gap_ok`=0. The first start after reset gives `res_ipd_ok`=0 with `res_ipd_bits`=0.
- R10: Every count saturates at its all-ones value instead of wrapping.
- R11: A cycle with `blk_valid` low adds no bits and no slots to any measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | A coded block is present this cycle |
| blk_sync | input | 2 | Sync header of the block |
| blk_type | input | 8 | Block-type byte (first payload byte) |
| res_valid | output | 1 | One-cycle result pulse |
| res_gap_ok | output | 1 | Gap fields hold a valid measurement |
| res_ipd_ok | output | 1 | Delay field holds a valid measurement |
| res_gap_idles | output | IDLE_W | Gap in idle character slots |
| res_gap_bits | output | BIT_W | Gap in line bit times |
| res_ipd_bits | output | BIT_W | Start-to-start delay in line bit times |

## Verification
A start block does two jobs in the same cycle. It closes the running gap, and it both reports and restarts the delay window. The new window's offset depends on the start lane.

The bench provokes this with back-to-back starts in lane 0 and lane 4, and with a lane-7 terminate directly followed by a lane-4 start. In those cases the closing gap, the reported delay and the next window's first block all meet in one cycle. A scoreboard judges every pulse against distances computed from absolute line positions, not from per-block increments.

// File: rtl/ipg_meter_pkg.sv
package ipg_meter_pkg;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

    localparam logic [7:0] TYPE_IDLE   = 8'h1E;
    localparam logic [7:0] TYPE_START0 = 8'h78;
    localparam logic [7:0] TYPE_START4 = 8'h33;

    typedef enum logic [2:0] {
        BK_DATA,
        BK_IDLE,
        BK_START,
        BK_TERM,
        BK_BAD
    } blk_kind_e;

    typedef struct packed {
        blk_kind_e  kind;
        logic [2:0] lane;
    } blk_info_t;

    function automatic blk_info_t decode_block(input logic [1:0] sync,
                                               input logic [7:0] btype);
        blk_info_t r;
        r.kind = BK_BAD;
        r.lane = 3'd0;
        if (sync == HDR_DATA) begin
            r.kind = BK_DATA;
        end else if (sync == HDR_CTRL) begin
            case (btype)
                TYPE_IDLE:   r.kind = BK_IDLE;
                TYPE_START0: begin r.kind = BK_START; r.lane = 3'd0; end
                TYPE_START4: begin r.kind = BK_START; r.lane = 3'd4; end
                8'h87:       begin r.kind = BK_TERM;  r.lane = 3'd0; end
                8'h99:       begin r.kind = BK_TERM;  r.lane = 3'd1; end
                8'hAA:       begin r.kind = BK_TERM;  r.lane = 3'd2; end
                8'hB4:       begin r.kind = BK_TERM;  r.lane = 3'd3; end
                8'hCC:       begin r.kind = BK_TERM;  r.lane = 3'd4; end
                8'hD2:       begin r.kind = BK_TERM;  r.lane = 3'd5; end
                8'hE1:       begin r.kind = BK_TERM;  r.lane = 3'd6; end
                8'hFF:       begin r.kind = BK_TERM;  r.lane = 3'd7; end
                default:     r.kind = BK_BAD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ipg_gap_accum.sv
module ipg_gap_accum
    import ipg_meter_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int BIT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_en,
    input  blk_info_t         info,
    output logic              gap_ok,
    output logic [IDLE_W-1:0] gap_idles,
    output logic [BIT_W-1:0]  gap_bits
);

    localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};
    localparam logic [BIT_W-1:0]  BIT_MAX  = {BIT_W{1'b1}};
    localparam int                BLK_BITS = 66;
    localparam int                SLOTS    = 8;

    function automatic logic [IDLE_W-1:0] add_idle(input logic [IDLE_W-1:0] a,
                                                   input logic [IDLE_W-1:0] b);
        logic [IDLE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[IDLE_W] ? IDLE_MAX : s[IDLE_W-1:0];
    endfunction

    function automatic logic [BIT_W-1:0] add_bits(input logic [BIT_W-1:0] a,
                                                  input logic [BIT_W-1:0] b);
        logic [BIT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BIT_W] ? BIT_MAX : s[BIT_W-1:0];
    endfunction

    logic              in_gap_q;
    logic [IDLE_W-1:0] idle_q;
    logic [BIT_W-1:0]  bits_q;
    logic [2:0]        tail_slots;

    assign tail_slots = 3'd7 - info.lane;

    // Closing values for a start block in this cycle
    assign gap_ok    = in_gap_q;
    assign gap_idles = add_idle(idle_q, IDLE_W'(info.lane));
    assign gap_bits  = add_bits(bits_q, BIT_W'({info.lane, 3'b000}) + BIT_W'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            in_gap_q <= 1'b0;
            idle_q   <= '0;
            bits_q   <= '0;
        end else if (blk_en) begin
            case (info.kind)
                BK_TERM: begin
                    in_gap_q <= 1'b1;
                    idle_q   <= IDLE_W'(tail_slots);
                    bits_q   <= BIT_W'({tail_slots, 3'b000});
                end
                BK_IDLE: begin
                    if (in_gap_q) begin
                        idle_q <= add_idle(idle_q, IDLE_W'(SLOTS));
                        bits_q <= add_bits(bits_q, BIT_W'(BLK_BITS));
                    end
                end
                default: begin
                    in_gap_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ipg_ipd_accum.sv
module ipg_ipd_accum
    import ipg_meter_pkg::*;
#(
    parameter int BIT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_en,
    input  blk_info_t        info,
    output logic             ipd_ok,
    output logic [BIT_W-1:0] ipd_bits
);

    localparam logic [BIT_W-1:0] BIT_MAX  = {BIT_W{1'b1}};
    localparam int               BLK_BITS = 66;

    function automatic logic [BIT_W-1:0] add_bits(input logic [BIT_W-1:0] a,
                                                  input logic [BIT_W-1:0] b);
        logic [BIT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BIT_W] ? BIT_MAX : s[BIT_W-1:0];
    endfunction

    logic             seen_q;
    logic [BIT_W-1:0] acc_q;
    logic [6:0]       start_off;

    assign start_off = {1'b0, info.lane, 3'b000};
    assign ipd_ok    = seen_q;
    assign ipd_bits  = add_bits(acc_q, BIT_W'(start_off) + BIT_W'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            acc_q  <= '0;
        end else if (blk_en) begin
            if (info.kind == BK_START) begin
                seen_q <= 1'b1;
                acc_q  <= BIT_W'(7'd64 - start_off);
            end else begin
                acc_q  <= add_bits(acc_q, BIT_W'(BLK_BITS));
            end
        end
    end

endmodule

// File: rtl/ipg_bit_meter.sv
module ipg_bit_meter
    import ipg_meter_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int BIT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_valid,
    input  logic [1:0]        blk_sync,
    input  logic [7:0]        blk_type,
    output logic              res_valid,
    output logic              res_gap_ok,
    output logic              res_ipd_ok,
    output logic [IDLE_W-1:0] res_gap_idles,
    output logic [BIT_W-1:0]  res_gap_bits,
    output logic [BIT_W-1:0]  res_ipd_bits
);

    blk_info_t         info;
    logic              gap_ok;
    logic [IDLE_W-1:0] gap_idles;
    logic [BIT_W-1:0]  gap_bits;
    logic              ipd_ok;
    logic [BIT_W-1:0]  ipd_bits;
    logic              is_start;

    assign info     = decode_block(blk_sync, blk_type);
    assign is_start = blk_valid && (info.kind == BK_START);

    ipg_gap_accum #(.IDLE_W(IDLE_W), .BIT_W(BIT_W)) gap_i (
        .clk       (clk),
        .rst       (rst),
        .blk_en    (blk_valid),
        .info      (info),
        .gap_ok    (gap_ok),
        .gap_idles (gap_idles),
        .gap_bits  (gap_bits)
    );

    ipg_ipd_accum #(.BIT_W(BIT_W)) ipd_i (
        .clk      (clk),
        .rst      (rst),
        .blk_en   (blk_valid),
        .info     (info),
        .ipd_ok   (ipd_ok),
        .ipd_bits (ipd_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_gap_ok    <= 1'b0;
            res_ipd_ok    <= 1'b0;
            res_gap_idles <= '0;
            res_gap_bits  <= '0;
            res_ipd_bits  <= '0;
        end else begin
            res_valid <= is_start;
            if (is_start) begin
                res_gap_ok    <= gap_ok;
                res_ipd_ok    <= ipd_ok;
                res_gap_idles <= gap_ok ? gap_idles : '0;
                res_gap_bits  <= gap_ok ? gap_bits  : '0;
                res_ipd_bits  <= ipd_ok ? ipd_bits  : '0;
            end
        end
    end

endmodule

// File: rtl/ipg_bit_meter_chk.sv
module ipg_bit_meter_chk #(
    parameter int IDLE_W = 16,
    parameter int BIT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              blk_valid,
    input logic [1:0]        blk_sync,
    input logic [7:0]        blk_type,
    input logic              res_valid,
    input logic              res_gap_ok,
    input logic              res_ipd_ok,
    input logic [IDLE_W-1:0] res_gap_idles,
    input logic [BIT_W-1:0]  res_gap_bits,
    input logic [BIT_W-1:0]  res_ipd_bits
);

    logic        start_in;
    logic [31:0] idles_x8;
    logic [31:0] bits_w;

    assign start_in = blk_valid && blk_sync == 2'b10 &&
                      (blk_type == 8'h78 || blk_type == 8'h33);
    assign idles_x8 = 32'(res_gap_idles) << 3;
    assign bits_w   = 32'(res_gap_bits);

    assert_start_yields_result_R3: assert property (@(posedge clk) disable iff (rst)
        start_in |=> res_valid);

    assert_result_needs_start_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(start_in));

    assert_quiet_when_idle_input_R11: assert property (@(posedge clk) disable iff (rst)
        !blk_valid |=> !res_valid);

    assert_discarded_gap_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_gap_ok) |-> (res_gap_idles == '0 && res_gap_bits == '0));

    assert_bits_cover_slots_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_gap_ok && res_gap_bits != {BIT_W{1'b1}}) |-> (bits_w >= idles_x8));

    assert_ipd_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ipd_ok) |-> (32'(res_ipd_bits) >= 32'd34));

endmodule

bind ipg_bit_meter ipg_bit_meter_chk #(.IDLE_W(IDLE_W), .BIT_W(BIT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .blk_valid     (blk_valid),
    .blk_sync      (blk_sync),
    .blk_type      (blk_type),
    .res_valid     (res_valid),
    .res_gap_ok    (res_gap_ok),
    .res_ipd_ok    (res_ipd_ok),
    .res_gap_idles (res_gap_idles),
    .res_gap_bits  (res_gap_bits),
    .res_ipd_bits  (res_ipd_bits)
);

// File: tb/ipg_bit_meter_tb_top.sv
`timescale 1ns/1ps
module ipg_bit_meter_tb_top;

    localparam int    IDLE_W = 8;
    localparam int    BIT_W  = 12;
    localparam longint IMAX  = (64'd1 << IDLE_W) - 1;
    localparam longint BMAX  = (64'd1 << BIT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              blk_valid = 1'b0;
    logic [1:0]        blk_sync = 2'b10;
    logic [7:0]        blk_type = 8'h1E;
    logic              res_valid;
    logic              res_gap_ok;
    logic              res_ipd_ok;
    logic [IDLE_W-1:0] res_gap_idles;
    logic [BIT_W-1:0]  res_gap_bits;
    logic [BIT_W-1:0]  res_ipd_bits;

    always #2.5 clk = ~clk;

    ipg_bit_meter #(.IDLE_W(IDLE_W), .BIT_W(BIT_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .blk_valid     (blk_valid),
        .blk_sync      (blk_sync),
        .blk_type      (blk_type),
        .res_valid     (res_valid),
        .res_gap_ok    (res_gap_ok),
        .res_ipd_ok    (res_ipd_ok),
        .res_gap_idles (res_gap_idles),
        .res_gap_bits  (res_gap_bits),
        .res_ipd_bits  (res_ipd_bits)
    );

    typedef struct {
        bit     gap_ok;
        bit     ipd_ok;
        longint idles;
        longint bits;
        longint ipd;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     errors = 0;
    bit     done   = 1'b0;

    // reference model on absolute line positions
    longint blk_n      = 0;
    longint term_char  = 0;
    longint term_pos   = 0;
    bit     gap_live   = 1'b0;
    bit     seen_start = 1'b0;
    longint prev_pos   = 0;

    function automatic longint clip(input longint v, input longint mx);
        return (v > mx) ? mx : v;
    endfunction

    function automatic logic [7:0] term_code(input int lane);
        case (lane)
            0: return 8'h87;
            1: return 8'h99;
            2: return 8'hAA;
            3: return 8'hB4;
            4: return 8'hCC;
            5: return 8'hD2;
            6: return 8'hE1;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic drive(input logic [1:0] s, input logic [7:0] t);
        @(posedge clk);
        #1;
        blk_valid = 1'b1;
        blk_sync  = s;
        blk_type  = t;
        blk_n++;
    endtask

    task automatic gap_cycle();
        @(posedge clk);
        #1;
        blk_valid = 1'b0;
    endtask

    task automatic send_start(input int lane, input string tag);
        exp_t   e;
        longint pos;
        longint ch;
        pos = 66 * blk_n + 2 + 8 * lane;
        ch  = 8 * blk_n + lane;
        e.gap_ok = gap_live;
        e.ipd_ok = seen_start;
        e.idles  = gap_live ? clip(ch - term_char, IMAX) : 0;
        e.bits   = gap_live ? clip(pos - term_pos, BMAX) : 0;
        e.ipd    = seen_start ? clip(pos - prev_pos, BMAX) : 0;
        e.tag    = tag;
        sb_q.push_back(e);
        gap_live   = 1'b0;
        seen_start = 1'b1;
        prev_pos   = pos;
        drive(2'b10, (lane == 0) ? 8'h78 : 8'h33);
    endtask

    task automatic send_term(input int lane);
        term_char = 8 * blk_n + lane + 1;
        term_pos  = 66 * blk_n + 2 + 8 * (lane + 1);
        gap_live  = 1'b1;
        drive(2'b10, term_code(lane));
    endtask

    task automatic send_idle();
        drive(2'b10, 8'h1E);
    endtask

    task automatic send_data();
        gap_live = 1'b0;
        drive(2'b01, 8'h5A);
    endtask

    task automatic send_other(input logic [1:0] s, input logic [7:0] t);
        gap_live = 1'b0;
        drive(s, t);
    endtask

    task automatic report(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %s expected %s", tag, act, exp);
        end
    endtask

    // monitor: compare every result pulse against the scoreboard
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb_q.size() == 0) begin
                report(1'b0, "R3 unexpected result", "pulse", "none");
            end else begin
                exp_t e;
                bit   ok;
                e  = sb_q.pop_front();
                ok = (res_gap_ok == e.gap_ok) && (res_ipd_ok == e.ipd_ok) &&
                     (longint'(res_gap_idles) == e.idles) &&
                     (longint'(res_gap_bits) == e.bits) &&
                     (longint'(res_ipd_bits) == e.ipd);
                report(ok, e.tag,
                       $sformatf("g%0d i%0d idl=%0d bits=%0d ipd=%0d", res_gap_ok, res_ipd_ok,
                                 res_gap_idles, res_gap_bits, res_ipd_bits),
                       $sformatf("g%0d i%0d idl=%0d bits=%0d ipd=%0d", e.gap_ok, e.ipd_ok,
                                 e.idles, e.bits, e.ipd));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        report(res_valid == 1'b0, "R1 reset state", $sformatf("%0d", res_valid), "0");

        // R9: first start, no gap and no prior start
        send_start(0, "R9 first start");
        send_data(); send_data();
        // R4 R5 R6: plain gap across one idle block
        send_term(2);
        send_idle();
        send_start(0, "R4 R5 R6 basic gap");

        // R2: every terminate lane with both start lanes
        for (int t = 0; t < 8; t++) begin
            send_data();
            send_term(t);
            send_idle();
            send_start((t % 2 == 0) ? 0 : 4, "R2 R4 R5 terminate lane sweep");
        end

        // same-cycle corner: lane 7 terminate then lane 4 start
        send_term(7);
        send_start(4, "R5 R6 lane7 to lane4 adjacent");
        // back-to-back starts, no terminate between (R9 gap not ok)
        send_start(0, "R9 start without terminate");
        send_start(4, "R6 adjacent starts");

        // R7: bad headers during a gap
        send_term(3);
        send_other(2'b00, 8'h1E);
        send_idle();
        send_start(0, "R7 header 00 discards gap");
        send_term(1);
        send_idle();
        send_other(2'b11, 8'h1E);
        send_start(4, "R7 header 11 discards gap");

        // R8: data block and unknown control type in a gap
        send_term(5);
        send_data();
        send_start(0, "R8 data block discards gap");
        send_term(4);
        send_other(2'b10, 8'h4B);
        send_start(0, "R8 unknown type discards gap");

        // R11: input pauses inside a gap
        send_term(6);
        gap_cycle(); gap_cycle();
        send_idle();
        gap_cycle(); gap_cycle(); gap_cycle();
        send_idle();
        send_start(4, "R11 pauses add nothing");

        // R10: long idle run saturates every count
        send_term(0);
        for (int k = 0; k < 70; k++) send_idle();
        send_start(0, "R10 saturation");
        send_term(0);
        send_idle();
        send_start(0, "R10 recovery after saturation");

        gap_cycle();
        repeat (4) @(negedge clk);
        report(sb_q.size() == 0, "R3 every start reported",
               $sformatf("%0d left", sb_q.size()), "0 left");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule